// File: doc/BRIEF.md
# Tile Pixel Generator

This block turns raster coordinates into an 8-bit color index for a display divided into 16x16 pixel tiles. Each tile can show four colors taken from a 256-value index space. Each pixel is stored as a 2-bit code. The code picks one of four color bytes that belong to the pixel's tile. Pixel timing arrives as inputs: a horizontal counter, a vertical counter and a display-enable flag. The output goes on to a palette stage that sits outside this block.

All data comes from an external byte-wide memory over a request/address/acknowledge port. The four color bytes for every tile in one tile row are kept on chip in two banks. One bank is displayed. The other is filled with the next row's colors during blanking cycles. The banks swap at the tile-row boundary. During active video, the only reads are the 2-bit-per-pixel bitmap bytes, four per tile per line. The bytes for the next tile are fetched while the current tile is being shown, so the output never waits on memory.

Top module: `tile_pixel_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it, `color_idx` is 0 and `mem_req` is low.
- R2: A pixel presented with `pix_de` low produces `color_idx` = 0.
- R3: In active line y, tile t (pixels 16t..16t+15), the pixel at offset p in the tile takes its 2-bit code from the bitmap byte at address BMP_BASE + y*TILES_X*4 + t*4 + p/4. Bits [7:6] hold the code for offset p%4 = 0, [5:4] for 1, [3:2] for 2 and [1:0] for 3.
- R4: An active pixel with code c in tile t on line y outputs the color byte at address ATTR_BASE + (y/16)*TILES_X*4 + t*4 + c.
- R5: Each active line causes exactly TILES_X*4 bitmap reads. All four bytes for a tile have been read before that tile's first pixel is presented.
- R6: A read into the color area (address >= ATTR_BASE) only starts after a cycle with `pix_de` low. Each displayed tile row is loaded exactly once per frame, with TILES_X*4 reads, plus one extra load of row 0 after reset.
- R7: All 16 lines of tile row r use row r's colors. The switch to the next row's colors happens between the last pixel of one row and the first pixel of the next.
- R8: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until a cycle with `mem_ack` high. `mem_rdata` is taken in that cycle, so each acknowledge delivers one byte.
- R9: `color_idx` for a pixel is valid two clock edges after the coordinates are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_x | input | X_W | Horizontal position, 0..H_TOTAL-1 |
| pix_y | input | Y_W | Vertical position, 0..V_TOTAL-1 |
| pix_de | input | 1 | High for pixels inside the visible area |
| mem_req | output | 1 | Read request to display memory |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_ack | input | 1 | Read completed, data valid |
| mem_rdata | input | 8 | Read data |
| color_idx | output | 8 | Color index of the pixel |

## Verification
The checks assume the following about the inputs:
- The coordinates step once per clock in raster order.
- `pix_de` is high exactly when x < TILES_X*16 and y < V_ACT.
- `mem_ack` appears only while a request is pending.
- Horizontal blanking is wide enough to prefetch the first tile of the next line and to load the next row's colors within one tile row, so a load is always complete when the banks swap.

The stimulus walks a full raster with a blank area 32 pixels wide and an initial vertical blanking period. The memory answers with one or two cycles of delay depending on the address, which stays inside those bounds while still varying the handshake timing.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [0:0] {
    CLI_BMP  = 1'b0,
    CLI_FILL = 1'b1
  } client_e;

  // 2-bit code for pixel slot 0..3 of a bitmap byte, high pair first
  function automatic logic [1:0] pick_code(input logic [7:0] b, input logic [1:0] slot);
    logic [1:0] c;
    case (slot)
      2'd0:    c = b[7:6];
      2'd1:    c = b[5:4];
      2'd2:    c = b[3:2];
      default: c = b[1:0];
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tpg_attr_ram.sv
module tpg_attr_ram #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W:0]   waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W:0]   raddr,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 2 ** (IDX_W + 1);

  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tpg_mem_seq.sv
module tpg_mem_seq import tpg_pkg::*; #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bmp_want,
  input  logic [ADDR_W-1:0] bmp_addr,
  input  logic              fill_want,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              bmp_done,
  output logic              fill_done
);
  logic    busy;
  client_e cli;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cli      <= CLI_BMP;
      mem_addr <= '0;
    end else if (!busy) begin
      if (bmp_want) begin
        busy     <= 1'b1;
        cli      <= CLI_BMP;
        mem_addr <= bmp_addr;
      end else if (fill_want) begin
        busy     <= 1'b1;
        cli      <= CLI_FILL;
        mem_addr <= fill_addr;
      end
    end else if (mem_ack) begin
      busy <= 1'b0;
    end
  end

  assign mem_req   = busy;
  assign bmp_done  = busy && mem_ack && (cli == CLI_BMP);
  assign fill_done = busy && mem_ack && (cli == CLI_FILL);
endmodule

// File: rtl/tpg_span_fetch.sv
module tpg_span_fetch #(
  parameter int ADDR_W = 18,
  parameter int BPS    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [ADDR_W-1:0]     go_addr,
  input  logic                  byte_done,
  input  logic [7:0]            rdata,
  input  logic                  span_start,
  output logic                  want,
  output logic [ADDR_W-1:0]     want_addr,
  output logic                  idle,
  output logic [BPS-1:0][7:0]   span_bytes
);
  localparam int K_W = (BPS > 1) ? $clog2(BPS) : 1;
  localparam int L_W = $clog2(BPS + 1);

  logic [ADDR_W-1:0]   base_q;
  logic [K_W-1:0]      k_q;
  logic [L_W-1:0]      left_q;
  logic [BPS-1:0][7:0] nxt_q;
  logic [BPS-1:0][7:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      k_q    <= '0;
      left_q <= '0;
    end else if (go) begin
      base_q <= go_addr;
      k_q    <= '0;
      left_q <= L_W'(BPS);
    end else if (byte_done && left_q != '0) begin
      k_q    <= k_q + K_W'(1);
      left_q <= left_q - L_W'(1);
    end
  end

  // byte stores carry no reset so they map onto plain registers or RAM
  always_ff @(posedge clk) begin
    if (byte_done) nxt_q[k_q] <= rdata;
    if (span_start) cur_q <= nxt_q;
  end

  assign want       = (left_q != '0);
  assign want_addr  = base_q + ADDR_W'(k_q);
  assign idle       = (left_q == '0);
  assign span_bytes = span_start ? nxt_q : cur_q;
endmodule

// File: rtl/tile_pixel_gen.sv
module tile_pixel_gen import tpg_pkg::*; #(
  parameter int TILES_X   = 40,
  parameter int TILE      = 16,
  parameter int H_TOTAL   = 800,
  parameter int V_ACT     = 480,
  parameter int V_TOTAL   = 525,
  parameter int X_W       = 10,
  parameter int Y_W       = 10,
  parameter int ADDR_W    = 18,
  parameter int BMP_BASE  = 0,
  parameter int ATTR_BASE = 131072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic              pix_de,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        color_idx
);
  localparam int H_ACT      = TILES_X * TILE;
  localparam int BPS        = TILE / 4;
  localparam int LINE_BYTES = TILES_X * BPS;
  localparam int ROW_BYTES  = TILES_X * 4;
  localparam int ROWS       = V_ACT / TILE;
  localparam int TILE_W     = $clog2(TILE);
  localparam int TX_W       = $clog2(TILES_X);
  localparam int IDX_W      = TX_W + 2;
  localparam int CNT_W      = $clog2(ROW_BYTES + 1);
  localparam int ROW_W      = $clog2(ROWS + 1);

  // ---------------- raster event decode ----------------
  logic [X_W-1:0]    span_idx;
  logic [TILE_W-1:0] pos;
  logic [Y_W-1:0]    y_next;
  logic [Y_W-1:0]    new_row;
  logic              span_start, line_end, next_active, swap_evt;
  logic              bm_go;
  logic [ADDR_W-1:0] bm_go_addr;

  assign span_idx    = pix_x >> TILE_W;
  assign pos         = pix_x[TILE_W-1:0];
  assign y_next      = (pix_y == Y_W'(V_TOTAL - 1)) ? '0 : pix_y + Y_W'(1);
  assign new_row     = y_next >> TILE_W;
  assign next_active = (y_next < Y_W'(V_ACT));
  assign span_start  = pix_de && (pos == '0);
  assign line_end    = (pix_x == X_W'(H_ACT));
  assign swap_evt    = (pix_x == X_W'(H_TOTAL - 1)) && next_active &&
                       (y_next[TILE_W-1:0] == '0);

  always_comb begin
    bm_go      = 1'b0;
    bm_go_addr = '0;
    if (span_start && span_idx < X_W'(TILES_X - 1)) begin
      bm_go      = 1'b1;
      bm_go_addr = ADDR_W'(BMP_BASE) + ADDR_W'(pix_y) * ADDR_W'(LINE_BYTES) +
                   (ADDR_W'(span_idx) + ADDR_W'(1)) * ADDR_W'(BPS);
    end else if (line_end && next_active) begin
      bm_go      = 1'b1;
      bm_go_addr = ADDR_W'(BMP_BASE) + ADDR_W'(y_next) * ADDR_W'(LINE_BYTES);
    end
  end

  // ---------------- color row refill control ----------------
  logic              disp_bank;
  logic [ROW_W-1:0]  fill_row;
  logic [CNT_W-1:0]  fill_idx;
  logic              fill_done;
  logic              fill_want;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_pulse;
  logic [ROW_W-1:0]  row_after;

  assign fill_done = (fill_idx == CNT_W'(ROW_BYTES));
  assign fill_want = !fill_done && !pix_de;
  assign fill_addr = ADDR_W'(ATTR_BASE) + ADDR_W'(fill_row) * ADDR_W'(ROW_BYTES) +
                     ADDR_W'(fill_idx);
  assign row_after = ((new_row + Y_W'(1)) >= Y_W'(ROWS)) ? '0 :
                     ROW_W'(new_row + Y_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_bank <= 1'b0;
      fill_row  <= '0;
      fill_idx  <= '0;
    end else if (swap_evt) begin
      disp_bank <= ~disp_bank;
      fill_row  <= row_after;
      fill_idx  <= '0;
    end else if (fill_pulse && !fill_done) begin
      fill_idx <= fill_idx + CNT_W'(1);
    end
  end

  // ---------------- memory port and bitmap prefetch ----------------
  logic              bmp_want, bmp_pulse, bm_idle;
  logic [ADDR_W-1:0] bmp_addr;
  logic [BPS-1:0][7:0] span_bytes;

  tpg_mem_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .bmp_want (bmp_want),
    .bmp_addr (bmp_addr),
    .fill_want(fill_want),
    .fill_addr(fill_addr),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .bmp_done (bmp_pulse),
    .fill_done(fill_pulse)
  );

  tpg_span_fetch #(.ADDR_W(ADDR_W), .BPS(BPS)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .go        (bm_go),
    .go_addr   (bm_go_addr),
    .byte_done (bmp_pulse),
    .rdata     (mem_rdata),
    .span_start(span_start),
    .want      (bmp_want),
    .want_addr (bmp_addr),
    .idle      (bm_idle),
    .span_bytes(span_bytes)
  );

  // ---------------- pixel decode and color lookup ----------------
  logic [TX_W-1:0] tile;
  logic [7:0]      pix_byte;
  logic [1:0]      code;
  logic [IDX_W:0]  rd_addr;
  logic [7:0]      ram_q;
  logic            de_q;

  assign tile     = TX_W'(span_idx);
  assign pix_byte = span_bytes[pos[TILE_W-1:2]];
  assign code     = pick_code(pix_byte, pos[1:0]);
  assign rd_addr  = {disp_bank, tile, code};

  tpg_attr_ram #(.IDX_W(IDX_W)) u_ram (
    .clk  (clk),
    .we   (fill_pulse && !fill_done),
    .waddr({~disp_bank, fill_idx[IDX_W-1:0]}),
    .wdata(mem_rdata),
    .raddr(rd_addr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q      <= 1'b0;
      color_idx <= '0;
    end else begin
      de_q      <= pix_de;
      color_idx <= de_q ? ram_q : 8'd0;
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int ADDR_W    = 18,
  parameter int ATTR_BASE = 131072
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_de,
  input logic              de_q,
  input logic [7:0]        color_idx,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              span_start,
  input logic              bm_idle,
  input logic              swap_evt,
  input logic              fill_done
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (color_idx == 8'd0 && !mem_req));

  p_blank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !de_q |=> (color_idx == 8'd0));

  p_span_ready_r5: assert property (@(posedge clk) disable iff (rst)
    span_start |-> bm_idle);

  p_attr_in_blank_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_addr >= ADDR_W'(ATTR_BASE)) |-> !$past(pix_de));

  p_refill_in_time_r7: assert property (@(posedge clk) disable iff (rst)
    swap_evt |-> fill_done);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_ack_in_req_r8: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> mem_req);
endmodule

bind tile_pixel_gen tpg_checker #(.ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_de    (pix_de),
  .de_q      (de_q),
  .color_idx (color_idx),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .span_start(span_start),
  .bm_idle   (bm_idle),
  .swap_evt  (swap_evt),
  .fill_done (fill_done)
);

// File: tb/sim_tile_pixel_gen.sv
`timescale 1ns/1ps
module sim_tile_pixel_gen;
  localparam int TILES_X   = 4;
  localparam int TILE      = 16;
  localparam int H_ACT     = TILES_X * TILE;
  localparam int H_TOTAL   = 96;
  localparam int V_ACT     = 48;
  localparam int V_TOTAL   = 52;
  localparam int ADDR_W    = 18;
  localparam int BMP_BASE  = 0;
  localparam int ATTR_BASE = 131072;
  localparam int ROWS      = V_ACT / TILE;
  localparam int ROW_BYTES = TILES_X * 4;
  localparam int LINE_BYTES = TILES_X * 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [9:0]        pix_x = '0;
  logic [9:0]        pix_y = 10'(V_ACT);
  logic              pix_de = 1'b0;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack = 1'b0;
  logic [7:0]        mem_rdata = '0;
  logic [7:0]        color_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] exp;
    bit         de;
    int         x;
    int         y;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  tile_pixel_gen #(
    .TILES_X(TILES_X), .TILE(TILE), .H_TOTAL(H_TOTAL), .V_ACT(V_ACT),
    .V_TOTAL(V_TOTAL), .X_W(10), .Y_W(10), .ADDR_W(ADDR_W),
    .BMP_BASE(BMP_BASE), .ATTR_BASE(ATTR_BASE)
  ) u0 (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .color_idx(color_idx)
  );

  function automatic logic [7:0] mdata(input int a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 ^ (32'(a) >> 3) ^ 32'h5a3c;
    return t[7:0] ^ t[15:8];
  endfunction

  // expected color from the requirement formulas (R2, R3, R4)
  function automatic logic [7:0] expect_color(input int x, input int y, input bit de);
    int t, off, b, c;
    if (!de) return 8'd0;
    t   = x / TILE;
    off = x % TILE;
    b   = int'(mdata(BMP_BASE + y * LINE_BYTES + t * 4 + off / 4));
    c   = (b >> (6 - 2 * (off % 4))) & 3;
    return mdata(ATTR_BASE + (y / TILE) * ROW_BYTES + t * 4 + c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: odd addresses answer one cycle later
  bit waited = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mem_req && !mem_ack) begin
        if (mem_addr[0] && !waited) begin
          waited = 1'b1;
        end else begin
          mem_ack   = 1'b1;
          mem_rdata = mdata(int'(mem_addr));
          waited    = 1'b0;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic drive(input int x, input int y);
    item_t it;
    @(posedge clk);
    #1;
    rst    = 1'b0;
    pix_x  = 10'(x);
    pix_y  = 10'(y);
    pix_de = (x < H_ACT) && (y < V_ACT);
    it.de  = pix_de;
    it.x   = x;
    it.y   = y;
    it.exp = expect_color(x, y, pix_de);
    sb.push_back(it);
  endtask

  // monitor: scoreboard compare (R9 two-edge latency) and port traffic checks
  int  bmp_reads  = 0;
  int  attr_reads = 0;
  bit  req_prev   = 1'b0;
  bit  ack_prev   = 1'b0;
  bit  de_prev    = 1'b0;
  logic [ADDR_W-1:0] addr_prev = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() >= 3) begin
        item_t it;
        it = sb.pop_front();
        if (!it.de)
          check(color_idx == it.exp, "R2 R9 blank", color_idx, it.exp);
        else if (it.y % TILE == 0 || it.y % TILE == TILE - 1)
          check(color_idx == it.exp, "R4 R7 row edge", color_idx, it.exp);
        else
          check(color_idx == it.exp, "R3 R4 R9 pixel", color_idx, it.exp);
      end
      if (req_prev && !ack_prev)
        check(mem_req && mem_addr == addr_prev, "R8 hold", int'(mem_addr), int'(addr_prev));
      if (mem_req && !req_prev && mem_addr >= ADDR_W'(ATTR_BASE))
        check(!de_prev, "R6 blank only", int'(de_prev), 0);
      if (mem_req && mem_ack) begin
        if (mem_addr >= ADDR_W'(ATTR_BASE)) attr_reads++;
        else bmp_reads++;
      end
    end
    req_prev  = mem_req;
    ack_prev  = mem_ack;
    addr_prev = mem_addr;
    de_prev   = pix_de;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(color_idx == 8'd0, "R1 color", color_idx, 0);
    check(!mem_req, "R1 request", int'(mem_req), 0);
    drive(0, V_ACT);
    @(negedge clk);
    check(color_idx == 8'd0 && !mem_req, "R1 after release", color_idx, 0);
    for (int ln = 0; ln < 2 * V_TOTAL; ln++) begin
      for (int xx = (ln == 0) ? 1 : 0; xx < H_TOTAL; xx++)
        drive(xx, (V_ACT + ln) % V_TOTAL);
    end
    for (int k = 0; k < 4; k++) drive(k, V_ACT);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bmp_reads == 2 * V_ACT * LINE_BYTES, "R5 bitmap reads", bmp_reads,
          2 * V_ACT * LINE_BYTES);
    check(attr_reads == (1 + 2 * ROWS) * ROW_BYTES, "R6 color reads", attr_reads,
          (1 + 2 * ROWS) * ROW_BYTES);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule